// File: doc/BRIEF.md
# Reloadable Interval Timer with Square-Wave Output Bit

This block is a 16-bit down-counter paired with a 16-bit reload latch. Software reaches it through four byte-wide register offsets. It counts down once per clock. When it passes below zero it raises a one-cycle request that sets an interrupt flag held elsewhere. It can then either stop reporting further expiries, which is the one-shot use, or reload itself from the latch, which is the periodic use. Accesses that acknowledge the timer produce a separate one-cycle request that clears that flag.

The timer also owns a single output bit. This bit is kept apart from the port B output register that the programmer writes. When the square-wave mode is on, the port B output mux is told to override bit 7 with this bit and to force bit 7 to be an output. A start write drives the bit low. Each reported expiry inverts it. A write of the control register with the square-wave mode off puts it back high. The two mode bits (reload and square-wave) come from a control register outside the block, together with a strobe that marks a write of that register.

Top module: `pulse_timer`

## Requirements
- R1: After reset the counter and latch hold 0, the wave bit is 1, and irq_set and irq_clr are 0.
- R2: A write at offset 4 or offset 6 changes only the low byte of the latch. The counter and the latch high byte are not affected.
- R3: A write at offset 7 changes only the latch high byte and pulses irq_clr in the next cycle. The counter keeps counting.
- R4: A write at offset 5 stores the latch high byte and arms the timer. In the next cycle the counter holds {written byte, latch low byte} and irq_clr pulses. No expiry is reported for the cycle in which that write occurs.
- R5: bus_rdata is combinational from bus_addr: offset 4 gives the counter low byte, 5 the counter high byte, 6 the latch low byte, 7 the latch high byte, and any other offset gives 0. A read at offset 4 pulses irq_clr in the next cycle.
- R6: In every cycle without a load or a reload, the counter decreases by one, and it wraps from 0x0000 to 0xFFFF.
- R7: A cycle in which the counter is 0 and no start write occurs is an expiry. If the timer is armed, irq_set pulses in the next cycle. With cfg_continuous=1 the counter shows 0xFFFF for one cycle and then loads the latch, so the period is latch+2 cycles. With cfg_continuous=0 the timer disarms and reports no further expiry until the next start write.
- R8: While cfg_wave_en=1, a start write drives wave_bit to 0 and each reported expiry inverts it. While cfg_wave_en=0, neither of these events changes it.
- R9: A cycle with cfg_write=1 and cfg_wave_en=0 sets wave_bit to 1, and this takes priority over everything else. With cfg_wave_en=1, cfg_write alone leaves the bit unchanged.
- R10: wave_override equals cfg_wave_en at all times.
- R11: An expiry in the same cycle as a read at offset 4 or a write at offset 7 produces both irq_set and irq_clr in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| cfg_continuous | input | 1 | 1 = reload from the latch on expiry |
| cfg_wave_en | input | 1 | 1 = timer drives port B bit 7 |
| cfg_write | input | 1 | Marks a control-register write carrying the cfg_* values |
| irq_set | output | 1 | One-cycle request to set the interrupt flag |
| irq_clr | output | 1 | One-cycle request to clear the interrupt flag |
| wave_bit | output | 1 | Timer-owned value for port B bit 7 |
| wave_override | output | 1 | Port B bit 7 is forced to output and takes wave_bit |

## Verification
The expiry and a flag-clearing access can fall in the same cycle. To provoke this, the bench waits until its model shows the counter at zero and then issues a read at offset 4, or a write at offset 7, in that exact cycle. A correct design raises both requests together in the following cycle, and the read returns 0x00. A start write issued in the zero cycle is also tested: it must reload the counter and suppress the expiry.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int OFS_CNT_LO = 4;
    localparam int OFS_CNT_HI = 5;
    localparam int OFS_LAT_LO = 6;
    localparam int OFS_LAT_HI = 7;

    // decoded bus access for one cycle
    typedef struct packed {
        logic wr_lo;      // latch low byte (offset 4 or 6)
        logic wr_start;   // latch high byte + start (offset 5)
        logic wr_hi;      // latch high byte only (offset 7)
        logic rd_lo;      // counter low read (offset 4)
    } tmr_acc_t;

endpackage

// File: rtl/tmr_latch.sv
module tmr_latch
    import ptmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  tmr_acc_t            acc,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] lat
);
    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } lat_st_t;

    lat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc.wr_lo)
            st_d.lo = wdata;
        if (acc.wr_start || acc.wr_hi)
            st_d.hi = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign lat = {st_q.hi, st_q.lo};
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             continuous,
    output logic [CNT_W-1:0] cnt,
    output logic             pend,
    output logic             fire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             pend;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    expire;

    always_comb begin
        expire = (st_q.cnt == '0) && !load;
        fire   = expire && st_q.armed;
        st_d      = st_q;
        st_d.pend = expire && continuous;
        if (load) begin
            st_d.cnt   = load_val;
            st_d.armed = 1'b1;
        end else if (st_q.pend) begin
            st_d.cnt = reload_val;
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        if (expire && !continuous)
            st_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign pend = st_q.pend;
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic fire,
    input  logic cfg_write,
    input  logic wave_en,
    output logic wave
);
    typedef struct packed {
        logic bit_v;
    } wave_st_t;

    wave_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_write && !wave_en)
            st_d.bit_v = 1'b1;
        else if (load && wave_en)
            st_d.bit_v = 1'b0;
        else if (fire && wave_en)
            st_d.bit_v = !st_q.bit_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.bit_v <= 1'b1;
        else
            st_q <= st_d;
    end

    assign wave = st_q.bit_v;
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
    import ptmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cfg_continuous,
    input  logic              cfg_wave_en,
    input  logic              cfg_write,
    output logic              irq_set,
    output logic              irq_clr,
    output logic              wave_bit,
    output logic              wave_override
);
    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        logic set;
        logic clr;
    } irq_st_t;

    tmr_acc_t         acc;
    irq_st_t          irq_d, irq_q;
    logic [CNT_W-1:0] lat_val;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] load_val;
    logic             reload_pend;
    logic             tmr_fire;

    always_comb begin
        acc.wr_lo    = bus_wr && (bus_addr == ADDR_W'(OFS_CNT_LO) ||
                                  bus_addr == ADDR_W'(OFS_LAT_LO));
        acc.wr_start = bus_wr && (bus_addr == ADDR_W'(OFS_CNT_HI));
        acc.wr_hi    = bus_wr && (bus_addr == ADDR_W'(OFS_LAT_HI));
        acc.rd_lo    = bus_rd && (bus_addr == ADDR_W'(OFS_CNT_LO));
    end

    assign load_val = {bus_wdata, lat_val[DATA_W-1:0]};

    tmr_latch #(.DATA_W(DATA_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .wdata (bus_wdata),
        .lat   (lat_val)
    );

    tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (acc.wr_start),
        .load_val   (load_val),
        .reload_val (lat_val),
        .continuous (cfg_continuous),
        .cnt        (cnt_val),
        .pend       (reload_pend),
        .fire       (tmr_fire)
    );

    tmr_wave u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (acc.wr_start),
        .fire      (tmr_fire),
        .cfg_write (cfg_write),
        .wave_en   (cfg_wave_en),
        .wave      (wave_bit)
    );

    always_comb begin
        irq_d.set = tmr_fire;
        irq_d.clr = acc.wr_start || acc.wr_hi || acc.rd_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= '0;
        else
            irq_q <= irq_d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_CNT_LO): bus_rdata = cnt_val[DATA_W-1:0];
            ADDR_W'(OFS_CNT_HI): bus_rdata = cnt_val[CNT_W-1:DATA_W];
            ADDR_W'(OFS_LAT_LO): bus_rdata = lat_val[DATA_W-1:0];
            ADDR_W'(OFS_LAT_HI): bus_rdata = lat_val[CNT_W-1:DATA_W];
            default:             bus_rdata = '0;
        endcase
    end

    assign irq_set       = irq_q.set;
    assign irq_clr       = irq_q.clr;
    assign wave_override = cfg_wave_en;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import ptmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                cfg_wave_en,
    input logic                cfg_write,
    input logic                irq_set,
    input logic                irq_clr,
    input logic                wave_bit,
    input logic [2*DATA_W-1:0] cnt_val,
    input logic [2*DATA_W-1:0] lat_val,
    input logic                reload_pend,
    input logic                tmr_fire
);
    localparam int CNT_W = 2 * DATA_W;

    logic start_wr, hi_wr;
    assign start_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CNT_HI));
    assign hi_wr    = bus_wr && (bus_addr == ADDR_W'(OFS_LAT_HI));

    a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (cnt_val == {$past(bus_wdata), $past(lat_val[DATA_W-1:0])}));

    a_r4_no_expiry_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> !irq_set);

    a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_wr && !reload_pend && cnt_val != '0) |=> (cnt_val == $past(cnt_val) - CNT_W'(1)));

    a_r7_set_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_fire |=> (irq_set && $past(cnt_val) == '0));

    a_r3_clear_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> irq_clr);

    a_r9_force_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_write && !cfg_wave_en) |=> wave_bit);
endmodule

bind pulse_timer tmr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .cfg_wave_en (cfg_wave_en),
    .cfg_write   (cfg_write),
    .irq_set     (irq_set),
    .irq_clr     (irq_clr),
    .wave_bit    (wave_bit),
    .cnt_val     (cnt_val),
    .lat_val     (lat_val),
    .reload_pend (reload_pend),
    .tmr_fire    (tmr_fire)
);

// File: tb/tb_pulse_timer.sv
`timescale 1ns/1ps
module tb_pulse_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cfg_continuous = 1'b0, cfg_wave_en = 1'b0, cfg_write = 1'b0;
    logic       irq_set, irq_clr, wave_bit, wave_override;

    always #2.5 clk = ~clk;

    pulse_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_continuous(cfg_continuous), .cfg_wave_en(cfg_wave_en),
        .cfg_write(cfg_write), .irq_set(irq_set), .irq_clr(irq_clr),
        .wave_bit(wave_bit), .wave_override(wave_override)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural reference model
    int m_cnt = 0, m_lat = 0, m_armed = 0, m_pend = 0, m_wave = 1, m_set = 0, m_clr = 0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_rd(int a);
        case (a)
            4: return m_cnt % 256;
            5: return m_cnt / 256;
            6: return m_lat % 256;
            7: return m_lat / 256;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_lat = 0; m_armed = 0; m_pend = 0; m_wave = 1; m_set = 0; m_clr = 0;
        end else begin
            int a, n_cnt, n_lat, n_armed, n_pend, n_wave;
            bit ld, exp_ev, fire;
            a      = int'(bus_addr);
            ld     = bus_wr && a == 5;
            exp_ev = (m_cnt == 0) && !ld;
            fire   = exp_ev && (m_armed != 0);
            n_lat  = m_lat;
            if (bus_wr && (a == 4 || a == 6)) n_lat = (m_lat / 256) * 256 + int'(bus_wdata);
            if (bus_wr && (a == 5 || a == 7)) n_lat = int'(bus_wdata) * 256 + m_lat % 256;
            n_armed = m_armed;
            if (ld) n_cnt = int'(bus_wdata) * 256 + m_lat % 256;
            else if (m_pend != 0) n_cnt = m_lat;
            else n_cnt = (m_cnt + 65535) % 65536;
            if (ld) n_armed = 1;
            if (exp_ev && !cfg_continuous) n_armed = 0;
            n_pend = (exp_ev && cfg_continuous) ? 1 : 0;
            n_wave = m_wave;
            if (cfg_write && !cfg_wave_en) n_wave = 1;
            else if (ld && cfg_wave_en) n_wave = 0;
            else if (fire && cfg_wave_en) n_wave = 1 - m_wave;
            m_set = fire ? 1 : 0;
            m_clr = (ld || (bus_wr && a == 7) || (bus_rd && a == 4)) ? 1 : 0;
            m_cnt = n_cnt; m_lat = n_lat; m_armed = n_armed; m_pend = n_pend; m_wave = n_wave;
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        if (rst_n && !done) begin
            #1;
            check("R5 rdata", int'(bus_rdata), exp_rd(int'(bus_addr)));
            check("R7 irq_set", int'(irq_set), m_set);
            check("R3 irq_clr", int'(irq_clr), m_clr);
            check("R8 wave_bit", int'(wave_bit), m_wave);
            check("R10 wave_override", int'(wave_override), int'(cfg_wave_en));
        end
    end

    // all drive tasks start and end at a falling edge
    task automatic cyc(bit w, bit r, int a, int d);
        bus_wr = w; bus_rd = r; bus_addr = 4'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic set_cfg(bit cont, bit wave);
        cfg_continuous = cont; cfg_wave_en = wave; cfg_write = 1;
        @(negedge clk);
        cfg_write = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_zero();
        int g = 0;
        while (m_cnt != 0 && g < 70000) begin @(negedge clk); g++; end
    endtask

    task automatic measure_period(string req, int exp);
        int g = 0, n = 0;
        while (!irq_set && g < 1000) begin @(negedge clk); g++; end
        do begin @(negedge clk); n++; end while (!irq_set && n < 1000);
        check(req, n, exp);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w0, cnt_sets;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 wave_bit", int'(wave_bit), 1);
        check("R1 irq_set", int'(irq_set), 0);
        check("R1 irq_clr", int'(irq_clr), 0);
        bus_addr = 4'd6; #1 check("R1 latch lo", int'(bus_rdata), 0);
        bus_addr = 4'd7; #1 check("R1 latch hi", int'(bus_rdata), 0);
        bus_addr = 4'd2; #1 check("R5 unmapped", int'(bus_rdata), 0);
        @(negedge clk);

        // R2 low byte via both offsets
        cyc(1, 0, 6, 8'h05);
        cyc(1, 0, 7, 8'h00);
        cyc(1, 0, 4, 8'h22);
        bus_addr = 4'd6; #1 check("R2 latch lo via offset 4", int'(bus_rdata), 8'h22);
        bus_addr = 4'd7; #1 check("R2 latch hi kept", int'(bus_rdata), 0);
        @(negedge clk);
        cyc(1, 0, 6, 8'h05);

        // R4 start, continuous, wave on
        set_cfg(1, 1);
        cyc(1, 0, 5, 8'h00);
        check("R4 wave low on start", int'(wave_bit), 0);
        check("R4 clr after start", int'(irq_clr), 1);
        bus_addr = 4'd4; #1 check("R4 counter loaded", int'(bus_rdata), 5);
        @(negedge clk);
        #1 check("R6 decrement", int'(bus_rdata), 4);
        @(negedge clk);
        measure_period("R7 continuous period latch+2", 7);
        w0 = int'(wave_bit);
        measure_period("R7 continuous period again", 7);
        check("R8 toggle per expiry", int'(wave_bit), 1 - w0);

        // R7 one-shot: single report
        set_cfg(0, 1);
        cyc(1, 0, 5, 8'h00);
        cnt_sets = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (irq_set) cnt_sets++; end
        check("R7 one-shot single expiry", cnt_sets, 1);
        check("R8 one-shot pulse ends high", int'(wave_bit), 1);

        // R9 control writes
        cyc(1, 0, 5, 8'h00);
        set_cfg(0, 1);
        check("R9 wave kept with mode on", int'(wave_bit), 0);
        set_cfg(0, 0);
        check("R9 forced high", int'(wave_bit), 1);
        check("R10 override off", int'(wave_override), 0);
        cyc(1, 0, 5, 8'h00);
        check("R8 start ignored with mode off", int'(wave_bit), 1);

        // R11 expiry with low-counter read
        set_cfg(1, 1);
        cyc(1, 0, 5, 8'h00);
        wait_zero();
        bus_rd = 1; bus_addr = 4'd4;
        #1 check("R11 read value at zero", int'(bus_rdata), 0);
        @(negedge clk);
        bus_rd = 0;
        check("R11 set with read", int'(irq_set), 1);
        check("R11 clr with read", int'(irq_clr), 1);

        // R11 expiry with latch-high write
        wait_zero();
        cyc(1, 0, 7, 8'h00);
        check("R11 set with high write", int'(irq_set), 1);
        check("R11 clr with high write", int'(irq_clr), 1);

        // R4 start in the zero cycle suppresses expiry
        wait_zero();
        cyc(1, 0, 5, 8'h00);
        check("R4 no expiry on start", int'(irq_set), 0);
        bus_addr = 4'd4; #1 check("R4 reload at zero", int'(bus_rdata), 5);
        @(negedge clk);

        // R7 latch zero gives period 2
        cyc(1, 0, 6, 8'h00);
        cyc(1, 0, 5, 8'h00);
        measure_period("R7 period with latch 0", 2);
        idle(5);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule